// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Sequencer

This block turns a single request from on-chip logic into one complete read or write transfer on a 16-bit, word-addressed bus that ends each transfer on an active-low acknowledge from the addressed device. The request carries a word address, a direction bit, two byte-lane enables and the write data. The block accepts it only while idle. It then walks a fixed chain of named states and drives the address, an address strobe, an upper and a lower data strobe, a read/write line and the write data enable.

Each named state (S0 to S7) lasts one clock of the block, so one clock stands for half a bus clock period. After S4 the sequencer samples the acknowledge. It enters S5 at once if the acknowledge is low, or parks in the wait state (WAIT) for as many clocks as the acknowledge stays high. Read data is taken from the bus at the end of S6 and is presented with a one-clock done pulse in S7. A saturating wait counter raises a stuck flag once a configurable number of wait states has passed without an acknowledge. The cycle keeps waiting regardless.

States and transitions: IDLE goes to S0 on an accepted request. S0 to S1 to S2 to S3 to S4 always advance. S4 and WAIT go to S5 when the acknowledge is low, and otherwise to WAIT. S5 to S6 to S7 always advance, and S7 returns to IDLE.

Top module: `abm_bus_master`

## Requirements
- R1: After reset the block is idle. req_ready is 1, both data strobes, the address strobe and bus_rw are 1, bus_doe is 0, done is 0 and stuck is 0.
- R2: A request (req_valid=1) is taken only on a clock where req_ready is 1. req_ready is 1 only in IDLE. A request raised while a cycle runs starts no extra cycle.
- R3: An accepted cycle lasts 8+k clocks with req_ready low, where k is the number of wait states. The address strobe is low for 5+k clocks, from S2 through S6, and bus_addr carries the requested address while it is low.
- R4: On a read, the enabled data strobes fall on the same clock as the address strobe, and bus_rw stays 1 for the whole cycle.
- R5: On a write, bus_rw is 0 whenever the address strobe is low. The write data is on bus_dout with bus_doe=1 from S3, and the data strobes fall two clocks after the address strobe, in S4.
- R6: The acknowledge is sampled at the end of S4 and at the end of each wait state. Each clock it is sampled high adds one wait state.
- R7: On a read, bus_din is captured at the end of S6 and appears on rd_data from S7 onward. rd_data keeps its value through later write cycles.
- R8: req_be[1] enables the upper strobe (data bits 15..8) and req_be[0] enables the lower strobe (bits 7..0), independently. A strobe whose enable is 0 stays high.
- R9: done is high for exactly one clock per accepted request, in S7.
- R10: stuck rises once WAIT_LIMIT wait states have passed with the acknowledge high, stays 1 until the cycle returns to IDLE, and does not end the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per named bus state |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High in IDLE, when a request is taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 2 | Byte enables: bit1 upper, bit0 lower |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-clock completion pulse |
| stuck | output | 1 | Acknowledge timeout flag |
| bus_addr | output | ADDR_W | Bus address, zero when not driven |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dout | output | DATA_W | Write data toward the bus |
| bus_doe | output | 1 | Write data enable |
| bus_din | input | DATA_W | Read data from the bus |
| bus_dtack_n | input | 1 | Transfer acknowledge, active low |

## Verification
The assertions assume that the acknowledge is released, high, whenever the address strobe is high. This lets the wait rule be checked as a plain relation between the acknowledge level and the next state. They also assume that bus_din is stable on the clock that leaves S6. The bench responder obeys both: it counts clocks while the address strobe is low, pulls the acknowledge low after a chosen latency, and releases it as soon as the strobe rises. It derives read data only from the address it sees. Latencies from zero to well past the stuck limit drive the wait-state and timeout behaviour.

// File: rtl/abm_pkg.sv
package abm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_S0   = 4'd1,
        ST_S1   = 4'd2,
        ST_S2   = 4'd3,
        ST_S3   = 4'd4,
        ST_S4   = 4'd5,
        ST_WAIT = 4'd6,
        ST_S5   = 4'd7,
        ST_S6   = 4'd8,
        ST_S7   = 4'd9
    } abm_state_e;

endpackage

// File: rtl/abm_seq_fsm.sv
module abm_seq_fsm
    import abm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ack_n,
    output abm_state_e state
);

    abm_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_S0;
            ST_S0:   state_nx = ST_S1;
            ST_S1:   state_nx = ST_S2;
            ST_S2:   state_nx = ST_S3;
            ST_S3:   state_nx = ST_S4;
            ST_S4:   state_nx = ack_n ? ST_WAIT : ST_S5;
            ST_WAIT: state_nx = ack_n ? ST_WAIT : ST_S5;
            ST_S5:   state_nx = ST_S6;
            ST_S6:   state_nx = ST_S7;
            ST_S7:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/abm_wait_timer.sv
module abm_wait_timer #(
    parameter int WAIT_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_wait,
    input  logic clear,
    output logic stuck
);

    localparam int CW = $clog2(WAIT_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAIT_LIMIT);

    logic [CW-1:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     wcnt <= '0;
        else if (clear)                 wcnt <= '0;
        else if (in_wait && wcnt < LIMIT) wcnt <= wcnt + 1'b1;
    end

    assign stuck = (wcnt >= LIMIT);

endmodule

// File: rtl/abm_xfer_regs.sv
module abm_xfer_regs #(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_be,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              cap_rd,
    input  logic [DATA_W-1:0] bus_din,
    output logic              cur_write,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LANES-1:0]  cur_be,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_be    <= '0;
            cur_wdata <= '0;
        end else if (load) begin
            cur_write <= in_write;
            cur_addr  <= in_addr;
            cur_be    <= in_be;
            cur_wdata <= in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (cap_rd) rd_data <= bus_din;
    end

endmodule

// File: rtl/abm_bus_master.sv
module abm_bus_master
    import abm_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int DATA_W     = 16,
    parameter int WAIT_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              stuck,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_as_n,
    output logic              bus_uds_n,
    output logic              bus_lds_n,
    output logic              bus_rw,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_dtack_n
);

    localparam int LANES = 2;

    abm_state_e        state;
    logic              start;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  cur_be;
    logic [DATA_W-1:0] cur_wdata;

    logic addr_on, as_on, ds_on, wr_phase, dout_on, done_on;

    assign start = req_valid && (state == ST_IDLE);

    abm_seq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ack_n (bus_dtack_n),
        .state (state)
    );

    abm_xfer_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .in_write  (req_write),
        .in_addr   (req_addr),
        .in_be     (req_be),
        .in_wdata  (req_wdata),
        .cap_rd    ((state == ST_S6) && !cur_write),
        .bus_din   (bus_din),
        .cur_write (cur_write),
        .cur_addr  (cur_addr),
        .cur_be    (cur_be),
        .cur_wdata (cur_wdata),
        .rd_data   (rd_data)
    );

    abm_wait_timer #(
        .WAIT_LIMIT (WAIT_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_wait (state == ST_WAIT),
        .clear   (state == ST_S7),
        .stuck   (stuck)
    );

    // Output decode per state
    always_comb begin
        addr_on  = 1'b0;
        as_on    = 1'b0;
        ds_on    = 1'b0;
        wr_phase = 1'b0;
        dout_on  = 1'b0;
        done_on  = 1'b0;
        unique case (state)
            ST_IDLE, ST_S0: ;
            ST_S1: addr_on = 1'b1;
            ST_S2: begin
                addr_on  = 1'b1;
                as_on    = 1'b1;
                ds_on    = !cur_write;
                wr_phase = cur_write;
            end
            ST_S3: begin
                addr_on  = 1'b1;
                as_on    = 1'b1;
                ds_on    = !cur_write;
                wr_phase = cur_write;
                dout_on  = cur_write;
            end
            ST_S4, ST_WAIT, ST_S5, ST_S6: begin
                addr_on  = 1'b1;
                as_on    = 1'b1;
                ds_on    = 1'b1;
                wr_phase = cur_write;
                dout_on  = cur_write;
            end
            ST_S7: begin
                addr_on  = 1'b1;
                wr_phase = cur_write;
                dout_on  = cur_write;
                done_on  = 1'b1;
            end
            default: ;
        endcase
    end

    assign req_ready = (state == ST_IDLE);
    assign done      = done_on;
    assign bus_addr  = addr_on ? cur_addr : '0;
    assign bus_as_n  = !as_on;
    assign bus_uds_n = !(ds_on && cur_be[1]);
    assign bus_lds_n = !(ds_on && cur_be[0]);
    assign bus_rw    = !wr_phase;
    assign bus_doe   = dout_on;
    assign bus_dout  = dout_on ? cur_wdata : '0;

endmodule

// File: rtl/abm_bus_master_chk.sv
module abm_bus_master_chk
    import abm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input abm_state_e state,
    input logic       req_ready,
    input logic       done,
    input logic       stuck,
    input logic       bus_as_n,
    input logic       bus_uds_n,
    input logic       bus_lds_n,
    input logic       bus_rw,
    input logic       bus_doe,
    input logic       bus_dtack_n
);

    // R2: ready only while no strobe is active
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_as_n && bus_uds_n && bus_lds_n && bus_rw));

    // R4: data strobes never active outside the address strobe
    a_r4_ds_within_as: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);

    // R5: write strobes only after data has been out for a clock
    a_r5_data_before_ds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rw && (!bus_uds_n || !bus_lds_n)) |-> (bus_doe && $past(bus_doe)));

    // R6: acknowledge high at the sample point keeps the cycle waiting
    a_r6_wait_on_high_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_S4 || state == ST_WAIT) && bus_dtack_n) |=> (state == ST_WAIT));

    // R6: acknowledge low at the sample point moves on to S5
    a_r6_go_on_low_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_S4 || state == ST_WAIT) && !bus_dtack_n) |=> (state == ST_S5));

    // R9: done is a single-clock pulse followed by idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R10: stuck only during the tail of a waiting cycle
    a_r10_stuck_window: assert property (@(posedge clk) disable iff (!rst_n)
        stuck |-> (state == ST_WAIT || state == ST_S5 || state == ST_S6 || state == ST_S7));

endmodule

bind abm_bus_master abm_bus_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .req_ready   (req_ready),
    .done        (done),
    .stuck       (stuck),
    .bus_as_n    (bus_as_n),
    .bus_uds_n   (bus_uds_n),
    .bus_lds_n   (bus_lds_n),
    .bus_rw      (bus_rw),
    .bus_doe     (bus_doe),
    .bus_dtack_n (bus_dtack_n)
);

// File: tb/test_abm_bus_master.sv
module test_abm_bus_master;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 23;
    localparam int DW = 16;
    localparam int LIM = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_be = 2'b00;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          done, stuck;
    logic [AW-1:0] bus_addr;
    logic          bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_doe;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din;
    logic          bus_dtack_n = 1'b1;

    int errors = 0;
    int checks = 0;
    int resp_delay = 3;
    int rcnt = 0;
    int pushed = 0;
    int dones = 0;
    logic [DW-1:0] last_rd = '0;
    bit finished = 0;

    typedef struct {
        bit            wr;
        logic [AW-1:0] addr;
        logic [1:0]    be;
        logic [DW-1:0] wdata;
        int            waits;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    abm_bus_master #(.ADDR_W(AW), .DATA_W(DW), .WAIT_LIMIT(LIM)) i_abm_bus_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rd_data(rd_data), .done(done), .stuck(stuck),
        .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
        .bus_lds_n(bus_lds_n), .bus_rw(bus_rw), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_dtack_n(bus_dtack_n)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'hC3, a[15:8] + 8'h11};
    endfunction

    assign bus_din = mem_word(bus_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Responder: acknowledge after resp_delay strobe clocks, release with strobe
    always @(negedge clk) begin
        if (bus_as_n) begin
            rcnt = 0;
            bus_dtack_n = 1'b1;
        end else begin
            rcnt++;
            bus_dtack_n = !(rcnt >= resp_delay);
        end
    end

    // Monitor
    int  as_cnt = 0, busy_cnt = 0, stuck_cnt = 0, ds_off = 0;
    bit  addr_bad = 0, rw_bad = 0, lane_bad = 0, wd_bad = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!req_ready) busy_cnt++;
            if (stuck) stuck_cnt++;
            if (!bus_as_n) begin
                as_cnt++;
                if (q.size() > 0) begin
                    if (bus_addr !== q[0].addr) addr_bad = 1;
                    if (bus_rw !== !q[0].wr) rw_bad = 1;
                    if (!bus_uds_n || !bus_lds_n) begin
                        if (ds_off == 0) ds_off = as_cnt;
                        if ({bus_uds_n, bus_lds_n} !== ~q[0].be) lane_bad = 1;
                        if (q[0].wr && (!bus_doe || bus_dout !== q[0].wdata)) wd_bad = 1;
                    end
                end
            end
            if (done) begin
                dones++;
                if (q.size() == 0) begin
                    check(0, "R2", "done without accepted request", 1, 0);
                end else begin
                    exp_t e;
                    int   ds_exp;
                    int   st_exp;
                    e = q.pop_front();
                    ds_exp = e.wr ? 3 : 1;
                    st_exp = (e.waits >= LIM) ? (e.waits - LIM + 3) : 0;
                    check(busy_cnt == 8 + e.waits, "R3", "busy clocks", busy_cnt, 8 + e.waits);
                    check(as_cnt == 5 + e.waits, "R6", "strobe clocks", as_cnt, 5 + e.waits);
                    check(!addr_bad, "R3", "address under strobe", addr_bad, 0);
                    check(!lane_bad, "R8", "lane strobes", lane_bad, 0);
                    if (e.wr) begin
                        check(!rw_bad, "R5", "rw low under strobe", rw_bad, 0);
                        check(!wd_bad, "R5", "write data at strobes", wd_bad, 0);
                        check(ds_off == ds_exp, "R5", "strobe delay", ds_off, ds_exp);
                        check(rd_data == last_rd, "R7", "rd_data held over write", rd_data, last_rd);
                    end else begin
                        check(!rw_bad, "R4", "rw high on read", rw_bad, 0);
                        check(ds_off == ds_exp, "R4", "strobes with address strobe", ds_off, ds_exp);
                        check(rd_data == mem_word(e.addr), "R7", "read data", rd_data, mem_word(e.addr));
                        last_rd = mem_word(e.addr);
                    end
                    check(stuck == (e.waits >= LIM), "R10", "stuck at done", stuck, e.waits >= LIM);
                    check(stuck_cnt == st_exp, "R10", "stuck clocks", stuck_cnt, st_exp);
                end
                as_cnt = 0; busy_cnt = 0; stuck_cnt = 0; ds_off = 0;
                addr_bad = 0; rw_bad = 0; lane_bad = 0; wd_bad = 0;
            end
        end
    end

    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [1:0] be,
                        input logic [DW-1:0] wd, input int k, input bit noise);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        resp_delay = 3 + k;
        e.wr = wr; e.addr = a; e.be = be; e.wdata = wd; e.waits = k;
        q.push_back(e);
        pushed++;
        req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (noise) begin
            // R2: request raised mid-cycle must be ignored
            check(!req_ready, "R2", "ready low while busy", req_ready, 0);
            req_write = ~wr; req_addr = ~a; req_be = 2'b11; req_wdata = ~wd;
            req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1, "R1", "req_ready", req_ready, 1);
        check({bus_as_n, bus_uds_n, bus_lds_n, bus_rw} == 4'hF, "R1", "strobes idle",
              {bus_as_n, bus_uds_n, bus_lds_n, bus_rw}, 4'hF);
        check(!bus_doe && !done && !stuck, "R1", "doe/done/stuck", {bus_doe, done, stuck}, 0);
        rst_n = 1'b1;

        xfer(0, 23'h012345, 2'b11, '0,       0, 0);
        xfer(1, 23'h00ABCD, 2'b11, 16'hBEEF, 0, 0);
        xfer(0, 23'h7F0102, 2'b10, '0,       1, 0);
        xfer(1, 23'h000040, 2'b01, 16'h1234, 3, 1);
        xfer(0, 23'h055AA5, 2'b01, '0,       8, 0);
        xfer(1, 23'h3C3C3C, 2'b10, 16'hA55A, 10, 0);
        xfer(0, 23'h111111, 2'b11, '0,       7, 0);
        xfer(0, 23'h222222, 2'b11, '0,       0, 1);

        @(negedge clk);
        while (!req_ready || q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        // R9: exactly one done per accepted request
        check(dones == pushed, "R9", "done count", dones, pushed);
        check(q.size() == 0, "R9", "outstanding items", q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule